// File: doc/BRIEF.md
# Two-Phase to Four-Phase Handshake Sequencer

This block drives the enable of a return-to-zero (four-phase) dual-rail function block placed between two level-encoded two-phase channels. It watches four inputs. Three are transition-signalled phases: the phase of the incoming word, the phase of the outgoing word, and the acknowledge phase returned by the right-hand neighbour. The fourth is the function block's four-phase completion level. From these it produces a level enable and a toggling acknowledge to the left-hand neighbour.

An evaluate phase starts only when three conditions hold together: a fresh input word is present, the previous reset has drained, and the right neighbour has taken the previous result. The evaluate phase ends as soon as the outgoing phase shows that the whole result has been emitted. At that point the enable drops to start return-to-zero. In pipeline mode the left acknowledge flips in the same cycle, so the next word can travel while the reset is still propagating. In client/server mode no acknowledge is exchanged, and neither the left toggle nor the right acknowledge takes part.

The block is a clocked state machine with three states: idle, evaluate and return-to-zero. All four inputs pass through a register stage of depth `SAMPLE_STAGES` (default 1) before the machine uses them.

Top module: `hs_bridge_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fb_enable` is 0 and `ack_left` is 0.
- R2: `fb_enable` rises only when three conditions hold together: `in_phase` differs from the phase of the last accepted word, the sampled `fb_done` is 0, and (in pipeline mode) `rack_phase` equals the phase of the last emitted result. At reset both remembered phases are 0.
- R3: If any one of the three conditions of R2 is missing, `fb_enable` stays 0 however long the other two hold.
- R4: While `fb_enable` is 1, a change of `out_phase` relative to the last emitted phase makes `fb_enable` fall.
- R5: With `pipe_mode`=1, `ack_left` inverts in exactly the cycle in which `fb_enable` falls, and at no other time.
- R6: While `fb_enable` is 1, `fb_done` has no effect: the enable stays high until `out_phase` changes.
- R7: After `fb_enable` falls, it does not rise again until the sampled `fb_done` has been 0, even if a new word and the right acknowledge are already present.
- R8: A new input word that arrives while return-to-zero is in progress is kept and starts the next evaluate once `fb_done` falls.
- R9: A rising and a falling transition of `in_phase` each count as one new word.
- R10: With `pipe_mode`=0, `ack_left` never changes, and `rack_phase` is not needed to start an evaluate.
- R11: With `SAMPLE_STAGES`=1, a change on an input that completes a condition moves `fb_enable` on the second rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pipe_mode | input | 1 | 1 = pipeline (acknowledges used), 0 = client/server |
| in_phase | input | 1 | Two-phase phase of the incoming word |
| out_phase | input | 1 | Two-phase phase of the outgoing word |
| rack_phase | input | 1 | Two-phase acknowledge from the right neighbour |
| fb_done | input | 1 | Four-phase completion of the function block |
| fb_enable | output | 1 | Level enable: 1 = evaluate, 0 = return-to-zero |
| ack_left | output | 1 | Two-phase acknowledge to the left neighbour |

## Verification
The hardest situation to reach is a new word that is already waiting while return-to-zero is held open by a high completion level. When completion finally drops, the machine must pass through idle and straight into evaluate. The stimulus builds this by raising `fb_done` during evaluate, then flipping `out_phase`, `in_phase` and `rack_phase` while `fb_done` is still held high for several cycles. It then releases `fb_done` and checks the enable edge by edge against a behavioural model. The same model follows the stimulus where each condition of the three-way check is withheld in turn, and where the mode is switched to client/server.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_RTZ  = 2'd2
  } hs_state_t;

  // A two-phase event is pending when the live phase differs from the consumed one
  function automatic logic phase_event(input logic now_ph, input logic last_ph);
    return now_ph ^ last_ph;
  endfunction

  // Three-way synchronization; right acknowledge waived outside pipeline mode
  function automatic logic eval_ready(input logic req, input logic rack_ok,
                                      input logic done, input logic pipe);
    return req && (rack_ok || !pipe) && !done;
  endfunction
endpackage

// File: rtl/hsc_sampler.sv
module hsc_sampler #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[g] <= '0;
      else if (g == 0) chain[g] <= d;
      else chain[g] <= chain[(g == 0) ? 0 : g-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hsc_event_flag.sv
module hsc_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic take,
  output logic pending,
  output logic seen
);
  import hsc_pkg::*;

  // seen holds the phase of the last consumed transition; a new edge sets pending
  always_ff @(posedge clk) begin
    if (!rst_n)    seen <= 1'b0;
    else if (take) seen <= sample;
  end

  assign pending = phase_event(sample, seen);
endmodule

// File: rtl/hsc_fsm.sv
module hsc_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic pipe_mode,
  input  logic req_pend,
  input  logic out_pend,
  input  logic rack_ok,
  input  logic done_s,
  output logic take_req,
  output logic take_out,
  output logic enable,
  output logic ack_left
);
  import hsc_pkg::*;

  hs_state_t state;
  logic      ack_q;
  logic      go;

  assign go       = eval_ready(req_pend, rack_ok, done_s, pipe_mode);
  assign take_req = (state == ST_IDLE) && go;
  assign take_out = (state == ST_EVAL) && out_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ack_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (go) state <= ST_EVAL;
        ST_EVAL: if (out_pend) begin
          state <= ST_RTZ;
          if (pipe_mode) ack_q <= ~ack_q;
        end
        ST_RTZ:  if (!done_s) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign enable   = (state == ST_EVAL);
  assign ack_left = ack_q;
endmodule

// File: rtl/hs_bridge_ctrl.sv
module hs_bridge_ctrl #(
  parameter int SAMPLE_STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pipe_mode,
  input  logic in_phase,
  input  logic out_phase,
  input  logic rack_phase,
  input  logic fb_done,
  output logic fb_enable,
  output logic ack_left
);
  localparam int NUM_IN   = 4;
  localparam int NUM_FLAG = 2;
  localparam int IDX_REQ  = 0;
  localparam int IDX_OUT  = 1;
  localparam int IDX_RACK = 2;
  localparam int IDX_DONE = 3;

  logic [NUM_IN-1:0]   raw_in;
  logic [NUM_IN-1:0]   smp;
  logic [NUM_FLAG-1:0] flag_take;
  logic [NUM_FLAG-1:0] flag_pend;
  logic [NUM_FLAG-1:0] flag_seen;

  // Named internal events for the checker
  logic req_pend, out_pend, rack_ok, done_s, req_seen, out_seen;
  logic take_req, take_out;

  assign raw_in = {fb_done, rack_phase, out_phase, in_phase};

  hsc_sampler #(.WIDTH(NUM_IN), .STAGES(SAMPLE_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(smp)
  );

  assign flag_take[IDX_REQ] = take_req;
  assign flag_take[IDX_OUT] = take_out;

  for (genvar f = 0; f < NUM_FLAG; f++) begin : g_flag
    hsc_event_flag u_flag (
      .clk(clk), .rst_n(rst_n), .sample(smp[f]), .take(flag_take[f]),
      .pending(flag_pend[f]), .seen(flag_seen[f])
    );
  end

  assign req_pend = flag_pend[IDX_REQ];
  assign out_pend = flag_pend[IDX_OUT];
  assign req_seen = flag_seen[IDX_REQ];
  assign out_seen = flag_seen[IDX_OUT];
  assign rack_ok  = (smp[IDX_RACK] == out_seen);
  assign done_s   = smp[IDX_DONE];

  hsc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
    .req_pend(req_pend), .out_pend(out_pend), .rack_ok(rack_ok), .done_s(done_s),
    .take_req(take_req), .take_out(take_out),
    .enable(fb_enable), .ack_left(ack_left)
  );
endmodule

// File: rtl/hs_bridge_checker.sv
module hs_bridge_checker (
  input logic clk,
  input logic rst_n,
  input logic pipe_mode,
  input logic fb_enable,
  input logic ack_left,
  input logic req_pend,
  input logic out_pend,
  input logic rack_ok,
  input logic done_s,
  input logic req_seen
);
  a_r2_rise_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb_enable) |-> $past(req_pend) && $past(rack_ok || !pipe_mode));

  a_r7_rise_after_rtz: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb_enable) |-> $past(!done_s));

  a_r9_word_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb_enable) |-> req_seen != $past(req_seen));

  a_r4_fall_on_out: assert property (@(posedge clk) disable iff (!rst_n)
    fb_enable && out_pend |=> !fb_enable);

  a_r6_hold_in_eval: assert property (@(posedge clk) disable iff (!rst_n)
    fb_enable && !out_pend |=> fb_enable);

  a_r5_ack_with_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fb_enable) && $past(pipe_mode) |-> ack_left != $past(ack_left));

  a_r5_ack_only_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(fb_enable) |-> $stable(ack_left));

  a_r10_server_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!pipe_mode) |-> $stable(ack_left));
endmodule

bind hs_bridge_ctrl hs_bridge_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
  .fb_enable(fb_enable), .ack_left(ack_left),
  .req_pend(req_pend), .out_pend(out_pend), .rack_ok(rack_ok),
  .done_s(done_s), .req_seen(req_seen)
);

// File: tb/hs_bridge_ctrl_bench.sv
module hs_bridge_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pipe_mode = 1'b1;
  logic in_phase = 1'b0, out_phase = 1'b0, rack_phase = 1'b0, fb_done = 1'b0;
  logic fb_enable, ack_left;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  hs_bridge_ctrl u_hs_bridge_ctrl (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
    .in_phase(in_phase), .out_phase(out_phase), .rack_phase(rack_phase),
    .fb_done(fb_done), .fb_enable(fb_enable), .ack_left(ack_left)
  );

  // Behavioural reference: previous-edge view of the inputs, remembered phases, mode
  int   m_mode;       // 0 idle, 1 evaluating, 2 draining
  bit   m_ack;
  bit   v_in, v_out, v_rack, v_done;
  bit   got_word, got_result;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_ack = 0; v_in = 0; v_out = 0; v_rack = 0; v_done = 0;
      got_word = 0; got_result = 0;
    end else begin
      if (m_mode == 0) begin
        if (v_in != got_word && (!pipe_mode || v_rack == got_result) && !v_done) begin
          m_mode = 1; got_word = v_in;
        end
      end else if (m_mode == 1) begin
        if (v_out != got_result) begin
          m_mode = 2; got_result = v_out;
          if (pipe_mode) m_ack = !m_ack;
        end
      end else if (!v_done) begin
        m_mode = 0;
      end
      v_in = in_phase; v_out = out_phase; v_rack = rack_phase; v_done = fb_done;
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (fb_enable !== (m_mode == 1) || ack_left !== m_ack) begin
        errors++;
        $display("FAIL model compare (R2 R4 R5): en=%0b ack=%0b expected en=%0b ack=%0b",
                 fb_enable, ack_left, (m_mode == 1), m_ack);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic mode);
    rst_n = 1'b0; pipe_mode = mode;
    in_phase = 0; out_phase = 0; rack_phase = 0; fb_done = 0;
    step(3);
    chk(fb_enable, 1'b0, "R1 enable in reset");
    chk(ack_left, 1'b0, "R1 ack in reset");
    rst_n = 1'b1;
    step(1);
    chk(fb_enable, 1'b0, "R1 enable after reset");
    chk(ack_left, 1'b0, "R1 ack after reset");
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    // first word, rising edge
    in_phase = 1; step(1);
    chk(fb_enable, 1'b0, "R11 not yet after one edge");
    step(1);
    chk(fb_enable, 1'b1, "R2 R11 enable rises");
    // completion toggling during evaluate is ignored
    fb_done = 1; step(3);
    chk(fb_enable, 1'b1, "R6 done high in eval");
    fb_done = 0; step(2);
    chk(fb_enable, 1'b1, "R6 done low in eval");
    fb_done = 1;
    // result emitted
    out_phase = 1; step(1);
    chk(fb_enable, 1'b1, "R4 still high one edge");
    step(1);
    chk(fb_enable, 1'b0, "R4 enable falls");
    chk(ack_left, 1'b1, "R5 ack toggles with fall");
    // new word (falling edge) and right ack during drain, done held high
    in_phase = 0; rack_phase = 1; step(4);
    chk(fb_enable, 1'b0, "R7 waits for completion low");
    chk(ack_left, 1'b1, "R5 ack steady in drain");
    fb_done = 0; step(2);
    chk(fb_enable, 1'b0, "R8 passes through idle");
    step(1);
    chk(fb_enable, 1'b1, "R8 R9 queued falling-edge word starts");
    out_phase = 0; step(2);
    chk(fb_enable, 1'b0, "R4 second fall");
    chk(ack_left, 1'b0, "R5 ack toggles back");
    // missing right acknowledge
    in_phase = 1; step(5);
    chk(fb_enable, 1'b0, "R3 no right ack");
    rack_phase = 0; step(1);
    chk(fb_enable, 1'b0, "R11 rack sampled only");
    step(1);
    chk(fb_enable, 1'b1, "R3 right ack completes set");
    fb_done = 1; out_phase = 1; step(2);
    chk(fb_enable, 1'b0, "R4 third fall");
    chk(ack_left, 1'b1, "R5 third toggle");
    // missing request
    rack_phase = 1; fb_done = 0; step(5);
    chk(fb_enable, 1'b0, "R3 no new word");
    // completion still high blocks start
    fb_done = 1; in_phase = 0; step(4);
    chk(fb_enable, 1'b0, "R3 completion high");
    fb_done = 0; step(1);
    chk(fb_enable, 1'b0, "R11 done sampled only");
    step(1);
    chk(fb_enable, 1'b1, "R3 completion low starts");
    out_phase = 0; step(2);
    chk(fb_enable, 1'b0, "R4 fourth fall");
    chk(ack_left, 1'b0, "R5 fourth toggle");

    // client/server mode
    do_reset(1'b0);
    in_phase = 1; step(2);
    chk(fb_enable, 1'b1, "R10 server start");
    fb_done = 1; out_phase = 1; step(2);
    chk(fb_enable, 1'b0, "R10 server fall");
    chk(ack_left, 1'b0, "R10 no left ack");
    fb_done = 0; in_phase = 0; step(3);
    chk(fb_enable, 1'b1, "R10 no right ack needed");
    chk(ack_left, 1'b0, "R10 ack still idle");
    out_phase = 0; step(3);
    chk(ack_left, 1'b0, "R10 ack idle after second word");

    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule